// File: doc/BRIEF.md
# Embedded Controller Host Command Port

This block sits between a byte-wide host interface and an internal register bus that reaches a 256-entry byte register space. The host cannot address that space directly. It talks to two host offsets: a data offset, and a control offset that returns the status flags when read and accepts a command code when written. Two handshake flags pace the exchange. The input flag shows that the host has written a byte the block has not yet taken. The output flag shows that a result byte is waiting for the host.

To read a register, the host sends the read command code and then the register address. The block runs one read cycle on the internal bus, places the returned byte in the data register and raises the output flag. To write a register, the host sends the write command code, the address and then the value. The block runs one write cycle. Before each write the host waits for the input flag to drop, and before it reads the data offset it waits for the output flag to rise. A command byte that arrives part way through a sequence discards that sequence and starts a new one.

Top module: `ec_host_port`

## Requirements
- R1: After reset the status byte reads 0x00, the data register holds 0x00 and `bus_req` is low.
- R2: A host write to offset 0 (data) or offset 4 (command) sets the input-pending flag, status bit 1, from the next cycle. Status bit 3 then reads 1 if that write went to offset 4 and 0 if it went to offset 0. A host write to any other offset changes nothing. A host read at offset 4 returns the status byte, a read at offset 0 returns the data register, and a read at any other offset returns 0x00.
- R3: A pending byte is taken one cycle after it was written, so status bit 1 falls then, unless an internal bus cycle is running. In that case the byte stays pending until the bus cycle ends.
- R4: Command 0x80 followed by an address byte starts exactly one read cycle on the bus (`bus_we`=0) at that address. In the cycle after `bus_ack`, the returned byte is in the data register and the result-ready flag, status bit 0, is set.
- R5: Command 0x81 followed by an address byte and a value byte starts exactly one write cycle on the bus (`bus_we`=1) carrying that address and value.
- R6: A host read at offset 0 clears status bit 0 from the next cycle. A host read at offset 4 leaves it unchanged.
- R7: A command byte other than 0x80 or 0x81 is taken and ignored. No bus cycle follows, and data bytes written after it start nothing.
- R8: A data byte written when no command is open is taken and ignored, with no bus cycle.
- R9: A command byte written after an open command's address or value byte, and before that command's bus cycle starts, discards the open command. Only the new command's bus cycle takes place.
- R10: `bus_req`, `bus_we`, `bus_addr` and `bus_wdata` stay constant from the start of a bus cycle until the cycle in which `bus_ack` is high, for any response delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| host_addr | input | HOST_AW (3) | Host offset: 0 = data, 4 = status/command |
| host_we | input | 1 | Host write strobe, one cycle per byte |
| host_rd | input | 1 | Host read strobe |
| host_wdata | input | DATA_W (8) | Byte written by the host |
| host_rdata | output | DATA_W (8) | Byte returned to the host |
| bus_req | output | 1 | Internal bus cycle active |
| bus_we | output | 1 | Internal bus cycle is a write |
| bus_addr | output | REG_AW (8) | Internal register address |
| bus_wdata | output | DATA_W (8) | Internal write value |
| bus_rdata | input | DATA_W (8) | Internal read value, valid with bus_ack |
| bus_ack | input | 1 | Internal bus cycle completes this cycle |

## Verification
The assertions assume that the host keeps to the flag protocol. It never writes while the input-pending flag is set, and the register side raises `bus_ack` only while `bus_req` is high. The bench's host tasks poll the status offset before every write and before every data read. Its register responder raises the acknowledge only in response to a request, after a delay the bench can program, so the stimulus never leaves these assumptions. Against this, a reference model with integer state follows every cycle, including commands that are discarded, commands that are unknown, stray data bytes and writes to unused offsets.

// File: rtl/ec_host_pkg.sv
package ec_host_pkg;
   typedef enum logic [2:0] {
      SQ_IDLE,
      SQ_ADDR,
      SQ_DATA,
      SQ_BUS_RD,
      SQ_BUS_WR
   } seq_state_e;

   localparam int ST_BIT_OBF = 0;
   localparam int ST_BIT_IBF = 1;
   localparam int ST_BIT_CMD = 3;
endpackage

// File: rtl/ec_host_regs.sv
module ec_host_regs #(
   parameter int DATA_W     = 8,
   parameter int HOST_AW    = 3,
   parameter int DATA_OFF   = 0,
   parameter int STATUS_OFF = 4,
   parameter bit RDATA_REG  = 1'b0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [HOST_AW-1:0] host_addr,
   input  logic               host_we,
   input  logic               host_rd,
   input  logic [DATA_W-1:0]  host_wdata,
   output logic [DATA_W-1:0]  host_rdata,
   input  logic               consume,
   input  logic               rd_load,
   input  logic [DATA_W-1:0]  rd_value,
   output logic               ibf,
   output logic               obf,
   output logic               cmd_flag,
   output logic [DATA_W-1:0]  in_byte
);
   import ec_host_pkg::*;

   localparam logic [HOST_AW-1:0] DATA_SEL = HOST_AW'(DATA_OFF);
   localparam logic [HOST_AW-1:0] STAT_SEL = HOST_AW'(STATUS_OFF);

   logic              sel_data;
   logic              sel_stat;
   logic              wr_hit;
   logic              rd_data_hit;
   logic [DATA_W-1:0] out_byte;
   logic [DATA_W-1:0] status_v;
   logic [DATA_W-1:0] rd_mux;

   assign sel_data    = (host_addr == DATA_SEL);
   assign sel_stat    = (host_addr == STAT_SEL);
   assign wr_hit      = host_we && (sel_data || sel_stat);
   assign rd_data_hit = host_rd && sel_data;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ibf      <= 1'b0;
         cmd_flag <= 1'b0;
         in_byte  <= '0;
      end else if (wr_hit) begin
         ibf      <= 1'b1;
         cmd_flag <= sel_stat;
         in_byte  <= host_wdata;
      end else if (consume) begin
         ibf      <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         obf      <= 1'b0;
         out_byte <= '0;
      end else if (rd_load) begin
         obf      <= 1'b1;
         out_byte <= rd_value;
      end else if (rd_data_hit) begin
         obf      <= 1'b0;
      end
   end

   always_comb begin
      status_v             = '0;
      status_v[ST_BIT_OBF] = obf;
      status_v[ST_BIT_IBF] = ibf;
      status_v[ST_BIT_CMD] = cmd_flag;
   end

   always_comb begin
      if (sel_stat)      rd_mux = status_v;
      else if (sel_data) rd_mux = out_byte;
      else               rd_mux = '0;
   end

   generate
      if (RDATA_REG) begin : g_rdata_flop
         logic [DATA_W-1:0] rdata_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) rdata_q <= '0;
            else        rdata_q <= rd_mux;
         end
         assign host_rdata = rdata_q;
      end else begin : g_rdata_comb
         assign host_rdata = rd_mux;
      end
   endgenerate
endmodule

// File: rtl/ec_host_seq.sv
module ec_host_seq #(
   parameter int               DATA_W    = 8,
   parameter int               REG_AW    = 8,
   parameter logic [DATA_W-1:0] CMD_READ  = 8'h80,
   parameter logic [DATA_W-1:0] CMD_WRITE = 8'h81
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ibf,
   input  logic              cmd_flag,
   input  logic [DATA_W-1:0] in_byte,
   output logic              consume,
   output logic              rd_load,
   output logic [DATA_W-1:0] rd_value,
   output logic              bus_req,
   output logic              bus_we,
   output logic [REG_AW-1:0] bus_addr,
   output logic [DATA_W-1:0] bus_wdata,
   input  logic [DATA_W-1:0] bus_rdata,
   input  logic              bus_ack
);
   import ec_host_pkg::*;

   seq_state_e        state_q;
   logic              is_rd_q;
   logic [REG_AW-1:0] addr_q;
   logic [DATA_W-1:0] wdata_q;
   logic              in_bus;

   assign in_bus  = (state_q == SQ_BUS_RD) || (state_q == SQ_BUS_WR);
   assign consume = ibf && !in_bus;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= SQ_IDLE;
         is_rd_q <= 1'b0;
         addr_q  <= '0;
         wdata_q <= '0;
      end else if (consume && cmd_flag) begin
         if (in_byte == CMD_READ) begin
            state_q <= SQ_ADDR;
            is_rd_q <= 1'b1;
         end else if (in_byte == CMD_WRITE) begin
            state_q <= SQ_ADDR;
            is_rd_q <= 1'b0;
         end else begin
            state_q <= SQ_IDLE;
         end
      end else if (consume) begin
         case (state_q)
            SQ_ADDR: begin
               addr_q  <= in_byte[REG_AW-1:0];
               state_q <= is_rd_q ? SQ_BUS_RD : SQ_DATA;
            end
            SQ_DATA: begin
               wdata_q <= in_byte;
               state_q <= SQ_BUS_WR;
            end
            default: state_q <= SQ_IDLE;
         endcase
      end else if (in_bus && bus_ack) begin
         state_q <= SQ_IDLE;
      end
   end

   assign rd_load   = (state_q == SQ_BUS_RD) && bus_ack;
   assign rd_value  = bus_rdata;
   assign bus_req   = in_bus;
   assign bus_we    = (state_q == SQ_BUS_WR);
   assign bus_addr  = addr_q;
   assign bus_wdata = wdata_q;
endmodule

// File: rtl/ec_host_port.sv
module ec_host_port #(
   parameter int                DATA_W     = 8,
   parameter int                REG_AW     = 8,
   parameter int                HOST_AW    = 3,
   parameter int                DATA_OFF   = 0,
   parameter int                STATUS_OFF = 4,
   parameter logic [DATA_W-1:0] CMD_READ   = 8'h80,
   parameter logic [DATA_W-1:0] CMD_WRITE  = 8'h81,
   parameter bit                RDATA_REG  = 1'b0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [HOST_AW-1:0] host_addr,
   input  logic               host_we,
   input  logic               host_rd,
   input  logic [DATA_W-1:0]  host_wdata,
   output logic [DATA_W-1:0]  host_rdata,
   output logic               bus_req,
   output logic               bus_we,
   output logic [REG_AW-1:0]  bus_addr,
   output logic [DATA_W-1:0]  bus_wdata,
   input  logic [DATA_W-1:0]  bus_rdata,
   input  logic               bus_ack
);
   localparam int HOST_SPAN = 1 << HOST_AW;

   generate
      if (DATA_W < 4)
         $error("DATA_W must hold status bit 3");
      if (REG_AW > DATA_W)
         $error("register address must fit in one host byte");
      if (DATA_OFF == STATUS_OFF)
         $error("data and status offsets must differ");
      if (DATA_OFF >= HOST_SPAN || STATUS_OFF >= HOST_SPAN)
         $error("host offsets exceed HOST_AW");
      if (CMD_READ == CMD_WRITE)
         $error("command codes must differ");
   endgenerate

   logic              ibf_w;
   logic              obf_w;
   logic              cmd_flag_w;
   logic [DATA_W-1:0] in_byte_w;
   logic              consume_w;
   logic              rd_load_w;
   logic [DATA_W-1:0] rd_value_w;

   ec_host_regs #(
      .DATA_W(DATA_W), .HOST_AW(HOST_AW), .DATA_OFF(DATA_OFF),
      .STATUS_OFF(STATUS_OFF), .RDATA_REG(RDATA_REG)
   ) u_regs (
      .clk(clk), .rst_n(rst_n),
      .host_addr(host_addr), .host_we(host_we), .host_rd(host_rd),
      .host_wdata(host_wdata), .host_rdata(host_rdata),
      .consume(consume_w), .rd_load(rd_load_w), .rd_value(rd_value_w),
      .ibf(ibf_w), .obf(obf_w), .cmd_flag(cmd_flag_w), .in_byte(in_byte_w)
   );

   ec_host_seq #(
      .DATA_W(DATA_W), .REG_AW(REG_AW),
      .CMD_READ(CMD_READ), .CMD_WRITE(CMD_WRITE)
   ) u_seq (
      .clk(clk), .rst_n(rst_n),
      .ibf(ibf_w), .cmd_flag(cmd_flag_w), .in_byte(in_byte_w),
      .consume(consume_w), .rd_load(rd_load_w), .rd_value(rd_value_w),
      .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ack(bus_ack)
   );
endmodule

// File: rtl/ec_host_port_chk.sv
module ec_host_port_chk #(
   parameter int DATA_W     = 8,
   parameter int REG_AW     = 8,
   parameter int HOST_AW    = 3,
   parameter int DATA_OFF   = 0,
   parameter int STATUS_OFF = 4
) (
   input logic               clk,
   input logic               rst_n,
   input logic [HOST_AW-1:0] host_addr,
   input logic               host_we,
   input logic               host_rd,
   input logic               bus_req,
   input logic               bus_we,
   input logic [REG_AW-1:0]  bus_addr,
   input logic [DATA_W-1:0]  bus_wdata,
   input logic               bus_ack,
   input logic               ibf,
   input logic               obf,
   input logic               cmd_flag
);
   logic at_data;
   logic at_stat;
   assign at_data = (host_addr == HOST_AW'(DATA_OFF));
   assign at_stat = (host_addr == HOST_AW'(STATUS_OFF));

   // R2: accepted host write raises the pending flag
   p_ibf_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
      host_we && (at_data || at_stat) |=> ibf);

   // R2: command flag follows the offset of the last accepted write
   p_cmd_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
      host_we && (at_data || at_stat) |=> (cmd_flag == $past(at_stat)));

   // R3: pending byte taken one cycle later when no bus cycle runs
   p_ibf_take_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ibf && !bus_req && !host_we |=> !ibf);

   // R4: completed read raises the result-ready flag
   p_obf_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
      bus_req && !bus_we && bus_ack |=> obf);

   // R6: data-offset read drops the result-ready flag
   p_obf_clr_r6: assert property (@(posedge clk) disable iff (!rst_n)
      host_rd && at_data && !(bus_req && !bus_we && bus_ack) |=> !obf);

   // R10: bus cycle is held until acknowledged
   p_bus_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      bus_req && !bus_ack |=> bus_req && $stable(bus_we) &&
                              $stable(bus_addr) && $stable(bus_wdata));

   // R5: write qualifier only inside a bus cycle
   p_we_in_cycle_r5: assert property (@(posedge clk) disable iff (!rst_n)
      bus_we |-> bus_req);
endmodule

bind ec_host_port ec_host_port_chk #(
   .DATA_W(DATA_W), .REG_AW(REG_AW), .HOST_AW(HOST_AW),
   .DATA_OFF(DATA_OFF), .STATUS_OFF(STATUS_OFF)
) u_chk (
   .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_we(host_we),
   .host_rd(host_rd), .bus_req(bus_req), .bus_we(bus_we),
   .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ack(bus_ack),
   .ibf(ibf_w), .obf(obf_w), .cmd_flag(cmd_flag_w)
);

// File: tb/ec_host_port_test.sv
module ec_host_port_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] host_addr = 3'd0;
   logic       host_we = 1'b0;
   logic       host_rd = 1'b0;
   logic [7:0] host_wdata = 8'h00;
   logic [7:0] host_rdata;
   logic       bus_req;
   logic       bus_we;
   logic [7:0] bus_addr;
   logic [7:0] bus_wdata;
   logic [7:0] bus_rdata = 8'h00;
   logic       bus_ack = 1'b0;

   int vectors = 0;
   int misses  = 0;
   int lat     = 0;
   int wait_cnt = 0;
   int cycles  = 0;
   logic [7:0] mem [256];

   // reference model state
   int         m_ph = 0;   // 0 idle,1 addr,2 value,3 bus read,4 bus write
   bit         m_isrd = 0;
   bit         m_ibf = 0, m_obf = 0, m_cmdf = 0;
   logic [7:0] m_in = 0, m_out = 0, m_addr = 0, m_wd = 0;

   always #10 clk = ~clk;

   ec_host_port uut (
      .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_we(host_we),
      .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata),
      .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ack(bus_ack)
   );

   task automatic chk(input string tag, input int act, input int exp);
      vectors++;
      if (act != exp) begin
         misses++;
         $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
      end
   endtask

   // model and register space, updated on the clock edge
   always @(posedge clk) begin
      if (!rst_n) begin
         m_ph = 0; m_isrd = 0; m_ibf = 0; m_obf = 0; m_cmdf = 0;
         m_in = 0; m_out = 0; m_addr = 0; m_wd = 0;
      end else begin
         bit hit, take, n_ibf, n_obf, n_cmdf;
         int n_ph;
         logic [7:0] n_in;
         hit   = host_we && (host_addr == 3'd0 || host_addr == 3'd4);
         take  = m_ibf && (m_ph < 3);
         n_ibf = hit ? 1'b1 : (take ? 1'b0 : m_ibf);
         n_cmdf = hit ? (host_addr == 3'd4) : m_cmdf;
         n_in  = hit ? host_wdata : m_in;
         n_obf = m_obf;
         n_ph  = m_ph;
         if (take && m_cmdf) begin
            if (m_in == 8'h80) begin n_ph = 1; m_isrd = 1; end
            else if (m_in == 8'h81) begin n_ph = 1; m_isrd = 0; end
            else n_ph = 0;
         end else if (take) begin
            if (m_ph == 1) begin m_addr = m_in; n_ph = m_isrd ? 3 : 2; end
            else if (m_ph == 2) begin m_wd = m_in; n_ph = 4; end
            else n_ph = 0;
         end else if (m_ph >= 3 && bus_ack) begin
            if (m_ph == 3) begin m_out = bus_rdata; n_obf = 1; end
            else mem[m_addr] = m_wd;
            n_ph = 0;
         end
         if (!(m_ph == 3 && bus_ack) && host_rd && host_addr == 3'd0) n_obf = 0;
         m_ph = n_ph; m_ibf = n_ibf; m_obf = n_obf; m_cmdf = n_cmdf; m_in = n_in;
      end
   end

   // register-side responder with programmable delay
   always @(posedge clk) begin
      #5;
      if (bus_req) begin
         bus_ack = (wait_cnt >= lat);
         wait_cnt++;
      end else begin
         bus_ack = 1'b0;
         wait_cnt = 0;
      end
      bus_rdata = mem[bus_addr];
   end

   // per-cycle comparison against the model
   always @(negedge clk) begin
      if (rst_n) begin
         logic [7:0] st, er;
         st = {4'b0, m_cmdf, 1'b0, m_ibf, m_obf};
         er = (host_addr == 3'd0) ? m_out : (host_addr == 3'd4) ? st : 8'h00;
         chk("R2 host_rdata", host_rdata, er);
         chk("R10 bus_req", bus_req, (m_ph >= 3));
         chk("R5 bus_we", bus_we, (m_ph == 4));
         if (m_ph >= 3) chk("R4 bus_addr", bus_addr, m_addr);
         if (m_ph == 4) chk("R5 bus_wdata", bus_wdata, m_wd);
      end
   end

   task automatic poll(input int bitn, input bit want);
      for (int i = 0; i < 200; i++) begin
         @(posedge clk); #5;
         host_addr = 3'd4; host_rd = 1'b0; host_we = 1'b0;
         @(negedge clk);
         if (host_rdata[bitn] == want) return;
      end
      chk("R3 flag poll timeout", 0, 1);
   endtask

   task automatic put(input logic [2:0] off, input logic [7:0] b);
      poll(1, 1'b0);
      @(posedge clk); #5;
      host_addr = off; host_wdata = b; host_we = 1'b1;
      @(posedge clk); #5;
      host_we = 1'b0; host_addr = 3'd4;
   endtask

   task automatic get(output logic [7:0] b);
      poll(0, 1'b1);
      @(posedge clk); #5;
      host_addr = 3'd0; host_rd = 1'b1;
      @(negedge clk);
      b = host_rdata;
      @(posedge clk); #5;
      host_rd = 1'b0; host_addr = 3'd4;
   endtask

   task automatic settle(input int n);
      for (int i = 0; i < n; i++) @(posedge clk);
   endtask

   task automatic reg_write(input logic [7:0] a, input logic [7:0] v);
      put(3'd4, 8'h81); put(3'd0, a); put(3'd0, v);
      settle(lat + 4);
   endtask

   task automatic reg_read(input logic [7:0] a, output logic [7:0] v);
      put(3'd4, 8'h80); put(3'd0, a); get(v);
   endtask

   initial begin
      for (int i = 0; i < 2000000; i++) begin
         @(posedge clk);
         cycles++;
         if (cycles > 20000) begin
            chk("watchdog", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
         end
      end
   end

   initial begin
      logic [7:0] v;
      for (int i = 0; i < 256; i++) mem[i] = 8'(i * 7 + 3);
      settle(3);
      #5 rst_n = 1'b1;
      // R1: reset state
      host_addr = 3'd4;
      @(negedge clk);
      chk("R1 status after reset", host_rdata, 8'h00);
      chk("R1 bus_req after reset", bus_req, 0);
      host_addr = 3'd0;
      @(negedge clk);
      chk("R1 data after reset", host_rdata, 8'h00);

      // R5 write then R4 read back
      reg_write(8'h10, 8'hA5);
      chk("R5 written value", mem[8'h10], 8'hA5);
      reg_read(8'h10, v);
      chk("R4 read value", v, 8'hA5);
      poll(0, 1'b0);
      chk("R6 result flag cleared", host_rdata[0], 0);

      // R10 slow responder
      lat = 3;
      reg_write(8'h20, 8'h3C);
      chk("R10 slow write", mem[8'h20], 8'h3C);
      reg_read(8'h20, v);
      chk("R10 slow read", v, 8'h3C);
      lat = 1;

      // R6 status read does not clear the result flag
      put(3'd4, 8'h80); put(3'd0, 8'h10);
      poll(0, 1'b1);
      settle(2);
      @(negedge clk);
      chk("R6 flag kept by status read", host_rdata[0], 1);
      get(v);
      chk("R6 data after status reads", v, 8'hA5);

      // R7 unknown command, following bytes start nothing
      put(3'd4, 8'h42); put(3'd0, 8'h20); put(3'd0, 8'h77);
      settle(6);
      chk("R7 no write after unknown cmd", mem[8'h20], 8'h3C);
      chk("R7 no write at data address", mem[8'h77], 8'(8'h77 * 7 + 3));

      // R8 stray data byte
      put(3'd0, 8'h99);
      settle(4);
      reg_read(8'h10, v);
      chk("R8 stray byte ignored", v, 8'hA5);

      // R9 abort of open write by a read command
      put(3'd4, 8'h81); put(3'd0, 8'h30);
      put(3'd4, 8'h80); put(3'd0, 8'h20); get(v);
      chk("R9 restarted read", v, 8'h3C);
      chk("R9 aborted write absent", mem[8'h30], 8'(8'h30 * 7 + 3));

      // R2 write to an unused offset
      @(posedge clk); #5;
      host_addr = 3'd2; host_wdata = 8'h81; host_we = 1'b1;
      @(posedge clk); #5;
      host_we = 1'b0; host_addr = 3'd4;
      @(negedge clk);
      chk("R2 unused offset no flag", host_rdata[1], 0);
      host_addr = 3'd6;
      @(negedge clk);
      chk("R2 unused offset reads zero", host_rdata, 8'h00);

      // R2/R3 command flag and one-cycle take
      @(posedge clk); #5;
      host_addr = 3'd0; host_wdata = 8'h55; host_we = 1'b1;
      @(posedge clk); #5;
      host_we = 1'b0; host_addr = 3'd4;
      @(negedge clk);
      chk("R2 flag set, bit3 clear", host_rdata & 8'h0A, 8'h02);
      @(negedge clk);
      chk("R3 pending byte taken", host_rdata[1], 0);

      // R4 boundary address
      reg_write(8'hFF, 8'h5A);
      reg_read(8'hFF, v);
      chk("R4 top address", v, 8'h5A);

      settle(4);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
   end
endmodule